// File: doc/BRIEF.md
# Phase-Shifted Dual-Bridge Gate Generator

This block produces the eight gate signals for a pair of full H-bridges that are coupled through an isolation transformer. Each bridge runs as a square wave with equal halves. The input bridge starts its switching cycle at the counter origin. The output bridge runs the same wave, delayed by a programmable number of clock cycles. That delay is the shift, counted in the same units as the half switching period. It is the control variable for power transfer. Both legs of each bridge get a blanking gap at every commutation, during which the whole bridge is off.

The blanking gap costs effective shift when the inductor current starts a half cycle positive. An optional correction adds the clamped dead-time count to the shift when compensation is enabled and the current-sign flag is set. A phase lost to a dead time of Tdb at switching frequency fs is Tdb·2π·fs radians. Measured against a half period this is exactly Tdb, so the correction in counts equals the dead-time count. The block samples all settings only at the start of a full switching cycle. All pins are plain levels with no stream handshake, because the block carries no data flow.

Top module: `psdb_gate_gen`

## Requirements
- R1: While reset is active or `en` is low, both gate buses are all zero. The first clock edge with `en` high starts a new switching cycle at position 0. After `en` falls, the gates are zero following the next edge.
- R2: The block uses the effective half period H, which is `half_period` raised to a minimum of 4. The cycle position p runs from 0 to 2H-1. In the first half, `pri_gate` bits 0 and 3 are on; these are the diagonal high side of leg A and low side of leg B. In the second half, bits 1 and 2 are on. Within a half at offset c, a gate is on only when c >= DL.
- R3: The output bridge follows the same pattern in `sec_gate` at position (p - E) mod 2H. Bits 0 and 3 form one diagonal, and bits 1 and 2 form the other. E is the effective shift. A rising edge of `sec_gate` bit 0 therefore follows the rising edge of `pri_gate` bit 0 by E cycles.
- R4: No leg ever has both of its switches on. The leg pairs are bits {0,1} and {2,3} of each bus.
- R5: The blanking gap between the last on-cycle of one switch of a leg and the first on-cycle of its partner is exactly DL cycles. DL is `dead_time` limited to at most H/2-1.
- R6: When `comp_en` and `cur_pos` are both 1, E is `phase_shift` + DL. Otherwise E is `phase_shift` alone. A zero `cur_pos` adds nothing.
- R7: E is limited to at most H/2 (integer division). This is the shift of maximum power transfer.
- R8: Changes to `half_period`, `phase_shift`, `dead_time`, `comp_en` or `cur_pos` during a cycle take effect only from the next cycle's position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low forces gates off and rewinds the cycle |
| half_period | input | CW | Half switching period in clock cycles |
| phase_shift | input | CW | Commanded shift between bridges, in cycles |
| dead_time | input | CW | Blanking gap per commutation, in cycles |
| comp_en | input | 1 | Allow dead-time correction of the shift |
| cur_pos | input | 1 | Initial inductor current is positive |
| pri_gate | output | 4 | Input bridge gates: bit0/1 leg A high/low, bit2/3 leg B high/low |
| sec_gate | output | 4 | Output bridge gates, same bit layout |

## Verification
Gate outputs are registered. The value seen after the j-th clock edge with `en` high therefore reflects cycle position j. The bench raises `en` at a falling edge and samples after every later edge, so the expected position of each sample is simply its index. A setting changed in mid-cycle is expected to apply from index 2H onward, and not before. A fall of `en` is expected to clear the gates after exactly one edge. The bench computes every expected gate bit from H, DL and E for each sample. It also measures the shift between bridges and the blanking gap as index differences.

// File: rtl/psdb_pkg.sv
package psdb_pkg;
  // polarity of a bridge within its switching cycle
  typedef enum logic {HALF_POS = 1'b0, HALF_NEG = 1'b1} half_e;
  // smallest half period that leaves room for a shift and a gap
  localparam int MIN_HALF_PERIOD = 4;
endpackage

// File: rtl/psdb_cfg_shadow.sv
module psdb_cfg_shadow
  import psdb_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] hp_in,
  input  logic [CW-1:0] ph_in,
  input  logic [CW-1:0] dt_in,
  input  logic          comp_en,
  input  logic          cur_pos,
  output logic [CW-1:0] hp_q,
  output logic [CW-1:0] dt_q,
  output logic [CW-1:0] eff_q
);
  localparam logic [CW-1:0] HP_MIN = CW'(MIN_HALF_PERIOD);

  logic [CW-1:0] hp_c, halfw, dt_c, add_c, eff_c;
  logic [CW:0]   sum_c;

  always_comb begin
    hp_c  = (hp_in < HP_MIN) ? HP_MIN : hp_in;
    halfw = hp_c >> 1;
    dt_c  = (dt_in > halfw - 1'b1) ? halfw - 1'b1 : dt_in;
    // lost phase in half-period counts equals the gap length
    add_c = (comp_en && cur_pos) ? dt_c : '0;
    sum_c = {1'b0, ph_in} + {1'b0, add_c};
    eff_c = (sum_c > {1'b0, halfw}) ? halfw : sum_c[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hp_q  <= HP_MIN;
      dt_q  <= '0;
      eff_q <= '0;
    end else if (load) begin
      hp_q  <= hp_c;
      dt_q  <= dt_c;
      eff_q <= eff_c;
    end
  end

  // R8: settings hold between cycle starts
  p_hold_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(hp_q) && $stable(dt_q) && $stable(eff_q)));
  // R7: shift never passes a quarter period
  p_eff_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eff_q <= (hp_q >> 1));
  // R5: gap leaves each switch some on-time
  p_dead_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dt_q < (hp_q >> 1));
endmodule

// File: rtl/psdb_cycle_ctr.sv
module psdb_cycle_ctr
  import psdb_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] hp,
  output logic [CW-1:0] cnt,
  output half_e         half,
  output logic          cyc_end
);
  logic wrap;

  assign wrap    = (cnt == hp - 1'b1);
  assign cyc_end = en && wrap && (half == HALF_NEG);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt  <= '0;
      half <= HALF_POS;
    end else if (wrap) begin
      cnt  <= '0;
      half <= (half == HALF_POS) ? HALF_NEG : HALF_POS;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: each half ends after hp counts
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wrap) |=> (cnt == '0));
  p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt < hp));
endmodule

// File: rtl/psdb_bridge_dec.sv
module psdb_bridge_dec
  import psdb_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  half_e         half,
  input  logic [CW-1:0] pos,
  input  logic [CW-1:0] dead,
  output logic [3:0]    gate
);
  logic on_a, on_b;

  assign on_a = (half == HALF_POS) && (pos >= dead);
  assign on_b = (half == HALF_NEG) && (pos >= dead);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) gate <= '0;
    else               gate <= {on_a, on_b, on_b, on_a};
  end

  // R4: no leg shoots through
  p_leg_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate[0] && gate[1]) && !(gate[2] && gate[3]));
  // R5: with a gap programmed, a high side never follows its low side directly
  p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate[0]) && dead != '0) |-> !$past(gate[1]));
endmodule

// File: rtl/psdb_gate_gen.sv
module psdb_gate_gen
  import psdb_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] half_period,
  input  logic [CW-1:0] phase_shift,
  input  logic [CW-1:0] dead_time,
  input  logic          comp_en,
  input  logic          cur_pos,
  output logic [3:0]    pri_gate,
  output logic [3:0]    sec_gate
);
  localparam int NBR = 2;

  logic [CW-1:0] hp_q, dt_q, eff_q, cnt;
  half_e         half;
  logic          cyc_end, load;

  half_e         br_half [NBR];
  logic [CW-1:0] br_pos  [NBR];
  logic [3:0]    br_gate [NBR];

  assign load = !en || cyc_end;

  psdb_cfg_shadow #(.CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load),
    .hp_in(half_period), .ph_in(phase_shift), .dt_in(dead_time),
    .comp_en(comp_en), .cur_pos(cur_pos),
    .hp_q(hp_q), .dt_q(dt_q), .eff_q(eff_q)
  );

  psdb_cycle_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .en(en), .hp(hp_q),
    .cnt(cnt), .half(half), .cyc_end(cyc_end)
  );

  // output bridge sits eff_q counts behind the input bridge
  always_comb begin
    br_half[0] = half;
    br_pos[0]  = cnt;
    if (cnt >= eff_q) begin
      br_half[1] = half;
      br_pos[1]  = cnt - eff_q;
    end else begin
      br_half[1] = (half == HALF_POS) ? HALF_NEG : HALF_POS;
      br_pos[1]  = cnt + hp_q - eff_q;
    end
  end

  for (genvar b = 0; b < NBR; b++) begin : g_br
    psdb_bridge_dec #(.CW(CW)) u_dec (
      .clk(clk), .rst_n(rst_n), .en(en),
      .half(br_half[b]), .pos(br_pos[b]), .dead(dt_q),
      .gate(br_gate[b])
    );
  end

  assign pri_gate = br_gate[0];
  assign sec_gate = br_gate[1];

  // R1: disabled bridges are dark after one edge
  p_idle_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pri_gate == 4'b0 && sec_gate == 4'b0));
  // R3: the output bridge position stays inside a half period
  p_sec_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (br_pos[1] < hp_q));
endmodule

// File: tb/tb_psdb_gate_gen.sv
module tb_psdb_gate_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, comp_en = 1'b0, cur_pos = 1'b0;
  logic [CW-1:0] half_period = 8'd8, phase_shift = '0, dead_time = '0;
  logic [3:0] pri_gate, sec_gate;
  int checks = 0, errors = 0;

  psdb_gate_gen #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .half_period(half_period),
    .phase_shift(phase_shift), .dead_time(dead_time), .comp_en(comp_en),
    .cur_pos(cur_pos), .pri_gate(pri_gate), .sec_gate(sec_gate)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // expected {sec,pri} gates at cycle position j
  function automatic logic [7:0] expg(int j, int hp, int dl, int eff);
    int p, c, q, cb;
    bit h, hb, a, b, x, y;
    p  = j % (2*hp);
    h  = (p >= hp);
    c  = p % hp;
    a  = !h && c >= dl;
    b  = h && c >= dl;
    q  = (p - eff + 2*hp) % (2*hp);
    hb = (q >= hp);
    cb = q % hp;
    x  = !hb && cb >= dl;
    y  = hb && cb >= dl;
    return {x, y, y, x, a, b, b, a};
  endfunction

  task automatic run_cfg(input int hp, input int ph, input int dt, input bit ce, input bit cp);
    int hpl, hf, dl, e1, e2, r1, r5, q1last, gap;
    logic [7:0] g, e, prev;
    hpl = (hp < 4) ? 4 : hp;
    hf  = hpl / 2;
    dl  = (dt > hf - 1) ? hf - 1 : dt;
    e1  = ph + ((ce && cp) ? dl : 0);
    e1  = (e1 > hf) ? hf : e1;
    e2  = ph + 1 + ((ce && cp) ? dl : 0);
    e2  = (e2 > hf) ? hf : e2;
    @(negedge clk);
    en = 1'b0; half_period = CW'(hp); phase_shift = CW'(ph);
    dead_time = CW'(dt); comp_en = ce; cur_pos = cp;
    @(negedge clk);
    en = 1'b1;
    r1 = -1; r5 = -1; q1last = -1; gap = -1; prev = '0;
    for (int j = 0; j < 6*hpl; j++) begin
      @(negedge clk);
      g = {sec_gate, pri_gate};
      e = expg(j, hpl, dl, (j < 2*hpl) ? e1 : e2);
      chk(g[3:0] == e[3:0], "R2 primary pattern", g[3:0], e[3:0]);
      if (j < 2*hpl) chk(g[7:4] == e[7:4], "R3 R6 R7 secondary pattern", g[7:4], e[7:4]);
      else           chk(g[7:4] == e[7:4], "R8 cycle-start update", g[7:4], e[7:4]);
      chk(!(g[0]&&g[1]) && !(g[2]&&g[3]) && !(g[4]&&g[5]) && !(g[6]&&g[7]),
          "R4 leg exclusion", g, 0);
      if (j < 2*hpl) begin
        if (g[0] && !prev[0] && r1 < 0) r1 = j;
        if (g[4] && !prev[4] && r5 < 0) r5 = j;
        if (g[1] && !prev[1] && gap < 0) gap = j - q1last - 1;
        if (g[0]) q1last = j;
      end
      prev = g;
      if (j == hpl + 1) phase_shift = CW'(ph + 1);
    end
    chk(r5 - r1 == e1, "R3 R6 measured shift", r5 - r1, e1);
    chk(gap == dl, "R5 blanking gap", gap, dl);
    en = 1'b0;
    @(negedge clk);
    chk(pri_gate == 4'b0 && sec_gate == 4'b0, "R1 disable clears", {sec_gate, pri_gate}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pri_gate == 4'b0 && sec_gate == 4'b0, "R1 reset state", {sec_gate, pri_gate}, 0);
    rst_n = 1'b1;
    for (int hi = 0; hi < 4; hi++) begin
      int hp, hf;
      case (hi)
        0: hp = 3;
        1: hp = 6;
        2: hp = 8;
        default: hp = 9;
      endcase
      hf = ((hp < 4) ? 4 : hp) / 2;
      for (int ph = 0; ph <= hf + 1; ph++)
        for (int dt = 0; dt < 4; dt++)
          for (int m = 0; m < 3; m++)
            run_cfg(hp, ph, dt, m != 0, m == 2);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule